// File: doc/BRIEF.md
# Colour Look-up Table Host Port

This block is the byte-wide host side of a colour look-up table. The table holds 256 main colours and 4 overlay colours. Each colour is a red, green and blue triplet of 8-bit values. A host reaches the table through four ports chosen by a 2-bit register address:

- an index port that sets or reports the current entry;
- a main-colour data port;
- a small bank of control registers;
- an overlay-colour data port.

One internal pointer serves all three data ports. It is made of an entry index and a component counter. Component writes go first into a staging triplet. The table entry is only overwritten when the blue component arrives, so a half-written colour never reaches the display side.

The display side reads finished colours through a lookup port. The lookup port takes a 9-bit colour number and returns the packed 24-bit colour. A one-cycle flag reports every commit that actually altered an entry, so downstream logic can decide whether a redraw is needed.

Top module: `clut_host_port`

## Requirements
- R1: A write to port 0 sets the entry index to the written byte and clears the component counter. A read of port 0 returns the current entry index.
- R2: Writes to port 1 stage red, green and blue, in that order, as components 0, 1 and 2. The main entry is left unchanged until the third write. The third write commits the triplet to that entry, and the pointer moves to the next entry with the counter at 0.
- R3: After a commit to main entry 255, the entry index wraps to 0.
- R4: Reads of port 1 return red, then green, then blue of the indexed main entry. After blue, the pointer moves to the next entry, and it wraps from 255 to 0.
- R5: When the entry index is 4 to 7, port 2 reads and writes control register (index − 4). A port-2 access never moves the pointer.
- R6: When the entry index is outside 4 to 7, a port-2 write changes no control register, and a port-2 read returns 0.
- R7: When the entry index is below 4, port 3 stages and commits overlay entries the same way as port 1 does. After overlay entry 3, the pointer wraps to 0.
- R8: When the entry index is 4 or more, a port-3 write changes neither the pointer nor any overlay entry, and a port-3 read returns 0.
- R9: `pal_changed` is high for exactly the one cycle after a commit, and only when the committed triplet differs from the entry it replaces.
- R10: `lut_rgb` returns {R,G,B} of colour number `lut_idx`. Numbers 0–255 are main entries and 256–259 are overlay entries 0–3. Any larger number returns 0.
- R11: A synchronous low reset clears the entry index, the component counter, the staging triplet, all control registers and `pal_changed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Host access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Port select: 0 index, 1 main data, 2 control, 3 overlay data |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the addressed port, from the state before the access |
| pal_changed | output | 1 | One-cycle flag for a commit that altered an entry |
| lut_idx | input | 9 | Colour number for the display-side lookup |
| lut_rgb | output | 24 | Packed colour {R,G,B} |

## Verification
The bench builds the block with its default sizes: 256 main entries, 4 overlay entries and 4 control registers from index 4. With these sizes, a direct index load reaches both wrap points, entry 255 and overlay entry 3, so no long walk through the table is needed. The 4-to-7 control window sits right next to the overlay range, so indices 3, 4, 7 and 8 test every range-boundary decision of ports 2 and 3 with single loads.

// File: rtl/clut_pkg.sv
// Package clut_pkg
// Shared port encoding for the colour look-up table host interface.
// The port numbers are fixed because host software selects them directly.
package clut_pkg;
    typedef enum logic [1:0] {
        PORT_INDEX = 2'd0,
        PORT_MAIN  = 2'd1,
        PORT_CTRL  = 2'd2,
        PORT_OVL   = 2'd3
    } clut_port_e;

    // Number of colour components per entry (red, green, blue).
    localparam int COMPONENTS = 3;
endpackage

// File: rtl/clut_pointer.sv
// Module clut_pointer
// Holds the shared entry index and component counter.
// A load sets the index and clears the counter. A step advances the
// counter; after the last component it moves to the next entry and wraps
// at the main or overlay limit, depending on which port stepped.
// Assumes that load and step are never asserted together.
module clut_pointer #(
    parameter int IDX_W  = 8,
    parameter int MAIN_N = 256,
    parameter int OVL_N  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    input  logic             step_ovl,
    output logic [IDX_W-1:0] idx,
    output logic [1:0]       comp,
    output logic             last_comp
);
    localparam logic [IDX_W-1:0] MAIN_LAST = IDX_W'(MAIN_N - 1);
    localparam logic [IDX_W-1:0] OVL_LAST  = IDX_W'(OVL_N - 1);
    localparam logic [1:0]       COMP_LAST = 2'(clut_pkg::COMPONENTS - 1);

    logic [IDX_W-1:0] idx_next_entry;

    assign last_comp = (comp == COMP_LAST);

    // Pick the following entry with the wrap rule of the port that stepped.
    always_comb begin
        if (step_ovl)
            idx_next_entry = (idx == OVL_LAST) ? '0 : idx + 1'b1;
        else
            idx_next_entry = (idx == MAIN_LAST) ? '0 : idx + 1'b1;
    end

    // Pointer register: reset, load or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            comp <= '0;
        end else if (load) begin
            idx  <= load_val;
            comp <= '0;
        end else if (step) begin
            if (last_comp) begin
                idx  <= idx_next_entry;
                comp <= '0;
            end else begin
                comp <= comp + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clut_stage.sv
// Module clut_stage
// Staging triplet for component writes. Each write stores its byte in
// the slot named by the component counter. The outgoing triplet carries
// the incoming byte in place of the slot being written, so that the
// commit on the last component sees the complete new colour in the same cycle.
module clut_stage #(
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [1:0]          comp,
    input  logic [COMP_W-1:0]   wdata,
    output logic [3*COMP_W-1:0] triplet
);
    logic [COMP_W-1:0] hold [clut_pkg::COMPONENTS];

    // Capture one component per write; reset clears all slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < clut_pkg::COMPONENTS; i++)
                hold[i] <= '0;
        end else if (wr) begin
            for (int i = 0; i < clut_pkg::COMPONENTS; i++)
                if (comp == 2'(i))
                    hold[i] <= wdata;
        end
    end

    // Build {R,G,B}, with the byte being written standing in for its slot.
    always_comb begin
        for (int i = 0; i < clut_pkg::COMPONENTS; i++)
            triplet[(clut_pkg::COMPONENTS-1-i)*COMP_W +: COMP_W] =
                (wr && comp == 2'(i)) ? wdata : hold[i];
    end
endmodule

// File: rtl/clut_store.sv
// Module clut_store
// Colour storage for main and overlay entries, addressed by one colour
// number: main entries first, overlay entries after them.
// It has one write port and two read paths, a byte-wide host read and a
// packed display lookup. The entries are not reset. The changed flag is
// registered and compares the new triplet with the old one on each commit.
module clut_store #(
    parameter int COMP_W = 8,
    parameter int MAIN_N = 256,
    parameter int OVL_N  = 4,
    parameter int CNUM_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [CNUM_W-1:0]   commit_num,
    input  logic [3*COMP_W-1:0] commit_rgb,
    input  logic [CNUM_W-1:0]   host_num,
    input  logic [1:0]          host_comp,
    output logic [COMP_W-1:0]   host_byte,
    input  logic [CNUM_W-1:0]   look_num,
    output logic [3*COMP_W-1:0] look_rgb,
    output logic                changed
);
    localparam int TOTAL_N = MAIN_N + OVL_N;
    localparam logic [CNUM_W-1:0] NUM_LIMIT = CNUM_W'(TOTAL_N);

    logic [3*COMP_W-1:0] entry [TOTAL_N];
    logic [3*COMP_W-1:0] host_entry;

    // Write the committed triplet into its entry.
    always_ff @(posedge clk) begin
        if (commit)
            entry[commit_num] <= commit_rgb;
    end

    // Flag a commit whose triplet differs from the previous contents.
    always_ff @(posedge clk) begin
        if (!rst_n)
            changed <= 1'b0;
        else
            changed <= commit && (entry[commit_num] != commit_rgb);
    end

    // Host read: select one component of the addressed entry.
    always_comb begin
        host_entry = (host_num < NUM_LIMIT) ? entry[host_num] : '0;
        case (host_comp)
            2'd0:    host_byte = host_entry[3*COMP_W-1 -: COMP_W];
            2'd1:    host_byte = host_entry[2*COMP_W-1 -: COMP_W];
            2'd2:    host_byte = host_entry[COMP_W-1 -: COMP_W];
            default: host_byte = '0;
        endcase
    end

    // Display lookup: packed colour, or zero beyond the table.
    always_comb begin
        look_rgb = (look_num < NUM_LIMIT) ? entry[look_num] : '0;
    end
endmodule

// File: rtl/clut_ctrl_regs.sv
// Module clut_ctrl_regs
// Bank of byte-wide control registers, selected by a register number.
// The caller qualifies the write enable with the valid index range; this
// module only decodes the register number. All registers reset to zero.
module clut_ctrl_regs #(
    parameter int COMP_W = 8,
    parameter int CTRL_N = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [COMP_W-1:0] wdata,
    output logic [COMP_W-1:0] rdata
);
    logic [COMP_W-1:0] creg [CTRL_N];

    for (genvar g = 0; g < CTRL_N; g++) begin : g_reg
        // One register: cleared on reset, loaded when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                creg[g] <= '0;
            else if (wr && sel == SEL_W'(g))
                creg[g] <= wdata;
        end
    end

    // Read the selected register.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < CTRL_N; i++)
            if (sel == SEL_W'(i))
                rdata = creg[i];
    end
endmodule

// File: rtl/clut_host_port.sv
// Module clut_host_port
// Host register interface of a colour look-up table. The top level
// decodes the four ports and gates the control and overlay ports by
// their valid index ranges. It routes the shared pointer to the staging,
// storage and control units and multiplexes the read byte.
// Assumes at most one host access per cycle. Read data reflects the
// state before the access, and the access takes effect at the clock edge.
module clut_host_port #(
    parameter int COMP_W    = 8,
    parameter int MAIN_N    = 256,
    parameter int OVL_N     = 4,
    parameter int CTRL_BASE = 4,
    parameter int CTRL_N    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [1:0]          bus_addr,
    input  logic [COMP_W-1:0]   bus_wdata,
    output logic [COMP_W-1:0]   bus_rdata,
    output logic                pal_changed,
    input  logic [8:0]          lut_idx,
    output logic [3*COMP_W-1:0] lut_rgb
);
    import clut_pkg::*;

    localparam int IDX_W  = $clog2(MAIN_N);
    localparam int CNUM_W = $clog2(MAIN_N + OVL_N);
    localparam int SEL_W  = (CTRL_N > 1) ? $clog2(CTRL_N) : 1;
    localparam logic [IDX_W-1:0] CTRL_LO  = IDX_W'(CTRL_BASE);
    localparam logic [IDX_W:0]   CTRL_HI  = (IDX_W+1)'(CTRL_BASE + CTRL_N);
    localparam logic [IDX_W:0]   OVL_LIM  = (IDX_W+1)'(OVL_N);
    localparam logic [CNUM_W-1:0] OVL_OFS = CNUM_W'(MAIN_N);

    clut_port_e       port;
    logic [IDX_W-1:0] ptr_idx;
    logic [1:0]       ptr_comp;
    logic             ptr_last;
    logic             ctrl_ok, ovl_ok;
    logic             wr_idx, wr_main, rd_main, wr_ovl, rd_ovl, wr_ctrl;
    logic             step, commit;
    logic [CNUM_W-1:0] entry_num, look_num;
    logic [3*COMP_W-1:0] stage_rgb;
    logic [COMP_W-1:0] store_byte, ctrl_byte;
    logic [SEL_W-1:0]  ctrl_sel;

    // Decode the port and the access qualifiers for the current index.
    always_comb begin
        port    = clut_port_e'(bus_addr);
        ctrl_ok = (ptr_idx >= CTRL_LO) && ({1'b0, ptr_idx} < CTRL_HI);
        ovl_ok  = ({1'b0, ptr_idx} < OVL_LIM);
        wr_idx  = bus_sel &&  bus_we && port == PORT_INDEX;
        wr_main = bus_sel &&  bus_we && port == PORT_MAIN;
        rd_main = bus_sel && !bus_we && port == PORT_MAIN;
        wr_ovl  = bus_sel &&  bus_we && port == PORT_OVL && ovl_ok;
        rd_ovl  = bus_sel && !bus_we && port == PORT_OVL && ovl_ok;
        wr_ctrl = bus_sel &&  bus_we && port == PORT_CTRL && ctrl_ok;
        step    = wr_main || rd_main || wr_ovl || rd_ovl;
        commit  = (wr_main || wr_ovl) && ptr_last;
    end

    // Map the pointer to a colour number and a control-register number.
    always_comb begin
        if (port == PORT_OVL)
            entry_num = OVL_OFS + CNUM_W'(ptr_idx);
        else
            entry_num = CNUM_W'(ptr_idx);
        ctrl_sel = SEL_W'(ptr_idx - CTRL_LO);
        look_num = CNUM_W'(lut_idx);
    end

    clut_pointer #(
        .IDX_W (IDX_W),
        .MAIN_N(MAIN_N),
        .OVL_N (OVL_N)
    ) u_pointer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_idx),
        .load_val (IDX_W'(bus_wdata)),
        .step     (step),
        .step_ovl (port == PORT_OVL),
        .idx      (ptr_idx),
        .comp     (ptr_comp),
        .last_comp(ptr_last)
    );

    clut_stage #(
        .COMP_W(COMP_W)
    ) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_main || wr_ovl),
        .comp   (ptr_comp),
        .wdata  (bus_wdata),
        .triplet(stage_rgb)
    );

    clut_store #(
        .COMP_W(COMP_W),
        .MAIN_N(MAIN_N),
        .OVL_N (OVL_N),
        .CNUM_W(CNUM_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .commit_num(entry_num),
        .commit_rgb(stage_rgb),
        .host_num  (entry_num),
        .host_comp (ptr_comp),
        .host_byte (store_byte),
        .look_num  (look_num),
        .look_rgb  (lut_rgb),
        .changed   (pal_changed)
    );

    clut_ctrl_regs #(
        .COMP_W(COMP_W),
        .CTRL_N(CTRL_N),
        .SEL_W (SEL_W)
    ) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (wr_ctrl),
        .sel  (ctrl_sel),
        .wdata(bus_wdata),
        .rdata(ctrl_byte)
    );

    // Read multiplexer; out-of-range control and overlay reads return zero.
    always_comb begin
        case (port)
            PORT_INDEX: bus_rdata = COMP_W'(ptr_idx);
            PORT_MAIN:  bus_rdata = store_byte;
            PORT_CTRL:  bus_rdata = ctrl_ok ? ctrl_byte : '0;
            PORT_OVL:   bus_rdata = ovl_ok ? store_byte : '0;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/clut_host_port_chk.sv
// Module clut_host_port_chk
// Temporal checks on the host interface and the shared pointer,
// attached to every clut_host_port instance through a bind.
module clut_host_port_chk #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int OVL_N  = 4,
    parameter int CTRL_BASE = 4,
    parameter int CTRL_N = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [COMP_W-1:0] bus_wdata,
    input logic [COMP_W-1:0] bus_rdata,
    input logic              pal_changed,
    input logic [IDX_W-1:0]  ptr_idx,
    input logic [1:0]        ptr_comp
);
    // R1: an index write lands in the pointer with the counter cleared.
    assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 2'd0) |=>
            (ptr_idx == IDX_W'($past(bus_wdata)) && ptr_comp == 2'd0));

    // R2: the component counter never reaches the unused fourth slot.
    assert_comp_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_comp != 2'd3);

    // R5: a control-port access leaves the pointer where it was.
    assert_ctrl_no_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == 2'd2) |=> ($stable(ptr_idx) && $stable(ptr_comp)));

    // R6: a control read outside the window returns zero.
    assert_ctrl_oob_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == 2'd2 &&
         !(ptr_idx >= IDX_W'(CTRL_BASE) && 32'(ptr_idx) < CTRL_BASE + CTRL_N))
            |-> bus_rdata == '0);

    // R7: overlay stepping keeps the index inside the overlay range.
    assert_ovl_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == 2'd3 && 32'(ptr_idx) < OVL_N) |=>
            32'(ptr_idx) < OVL_N);

    // R8: an overlay write with the index out of range changes nothing.
    assert_ovl_oob_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 2'd3 && 32'(ptr_idx) >= OVL_N) |=>
            ($stable(ptr_idx) && $stable(ptr_comp)));

    // R9: the changed flag only follows a data write of the last component.
    assert_changed_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pal_changed |-> ($past(bus_sel && bus_we && bus_addr[0]) && $past(ptr_comp) == 2'd2));

    // R11: reset leaves the pointer at entry 0, component 0.
    assert_reset_ptr_R11: assert property (@(posedge clk)
        !rst_n |=> (ptr_idx == '0 && ptr_comp == 2'd0 && !pal_changed));
endmodule

bind clut_host_port clut_host_port_chk #(
    .IDX_W    (IDX_W),
    .COMP_W   (COMP_W),
    .OVL_N    (OVL_N),
    .CTRL_BASE(CTRL_BASE),
    .CTRL_N   (CTRL_N)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pal_changed(pal_changed),
    .ptr_idx    (ptr_idx),
    .ptr_comp   (ptr_comp)
);

// File: tb/clut_host_port_bench.sv
// Bench for clut_host_port: a table-driven bus sequence, then directed tests.
module clut_host_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        pal_changed;
    logic [8:0]  lut_idx = 9'd0;
    logic [23:0] lut_rgb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clut_host_port u_clut_host_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pal_changed(pal_changed), .lut_idx(lut_idx), .lut_rgb(lut_rgb)
    );

    typedef struct packed {
        logic       we;
        logic [1:0] addr;
        logic [7:0] wd;
        logic       chk;
        logic [7:0] exp;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'd0, 8'h05, 1'b0, 8'h00},  // R1 load entry 5
        '{1'b1, 2'd1, 8'h11, 1'b0, 8'h00},  // R2 red
        '{1'b1, 2'd1, 8'h22, 1'b0, 8'h00},  // R2 green
        '{1'b1, 2'd1, 8'h33, 1'b0, 8'h00},  // R2 blue, commit
        '{1'b1, 2'd0, 8'h05, 1'b0, 8'h00},  // R1 reload entry 5
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h05},  // R1 index readback
        '{1'b0, 2'd1, 8'h00, 1'b1, 8'h11},  // R4 red
        '{1'b0, 2'd1, 8'h00, 1'b1, 8'h22},  // R4 green
        '{1'b0, 2'd1, 8'h00, 1'b1, 8'h33},  // R4 blue
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h06},  // R4 advanced to entry 6
        '{1'b1, 2'd0, 8'h04, 1'b0, 8'h00},  // R5 index 4
        '{1'b1, 2'd2, 8'hA5, 1'b0, 8'h00},  // R5 control reg 0
        '{1'b0, 2'd2, 8'h00, 1'b1, 8'hA5},  // R5 readback
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h04},  // R5 pointer unmoved
        '{1'b1, 2'd0, 8'h02, 1'b0, 8'h00},  // R7 index 2
        '{1'b1, 2'd3, 8'h01, 1'b0, 8'h00},  // R7 red
        '{1'b1, 2'd3, 8'h02, 1'b0, 8'h00},  // R7 green
        '{1'b1, 2'd3, 8'h03, 1'b0, 8'h00},  // R7 blue, commit
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h03}   // R7 next overlay entry
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic op(input logic we, input logic [1:0] a, input logic [7:0] d,
                      output logic [7:0] rd);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        #2 rd = bus_rdata;
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        op(1'b1, a, d, dummy);
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] r;
        op(1'b0, a, 8'h00, r);
        check(req, 32'(r), 32'(exp));
    endtask

    task automatic look_chk(input string req, input logic [8:0] n, input logic [23:0] exp);
        lut_idx = n;
        #1 check(req, 32'(lut_rgb), 32'(exp));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: state after reset.
        #1 check("R11 changed low", 32'(pal_changed), 32'd0);
        rd_chk("R11 index zero", 2'd0, 8'h00);
        for (int k = 4; k < 8; k++) begin
            wr(2'd0, 8'(k));
            rd_chk("R11 control reg zero", 2'd2, 8'h00);
        end

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            op(VECS[i].we, VECS[i].addr, VECS[i].wd, r);
            if (VECS[i].chk)
                check($sformatf("table vec %0d (R1/R4/R5/R7)", i), 32'(r), 32'(VECS[i].exp));
        end
        idle();
        look_chk("R10 main entry 5", 9'd5, 24'h112233);
        look_chk("R7 overlay entry 2 at 258", 9'd258, 24'h010203);

        // R2 / R9: staging and changed flag.
        wr(2'd0, 8'd10); wr(2'd1, 8'hAA); wr(2'd1, 8'hBB); wr(2'd1, 8'hCC);
        idle();
        look_chk("R10 entry 10", 9'd10, 24'hAABBCC);
        wr(2'd0, 8'd10); wr(2'd1, 8'h01); wr(2'd1, 8'h02);
        idle();
        check("R9 no flag mid-triplet", 32'(pal_changed), 32'd0);
        look_chk("R2 entry held until blue", 9'd10, 24'hAABBCC);
        wr(2'd1, 8'h03);
        idle();
        check("R9 flag on differing commit", 32'(pal_changed), 32'd1);
        look_chk("R2 entry committed", 9'd10, 24'h010203);
        @(negedge clk);
        #1 check("R9 flag lasts one cycle", 32'(pal_changed), 32'd0);
        rd_chk("R2 pointer at next entry", 2'd0, 8'd11);
        wr(2'd0, 8'd10); wr(2'd1, 8'h01); wr(2'd1, 8'h02); wr(2'd1, 8'h03);
        idle();
        check("R9 no flag on identical commit", 32'(pal_changed), 32'd0);

        // R3 / R4: wrap at entry 255.
        wr(2'd0, 8'd255); wr(2'd1, 8'h7E); wr(2'd1, 8'h7F); wr(2'd1, 8'h80);
        rd_chk("R3 index wraps to 0", 2'd0, 8'h00);
        idle();
        look_chk("R3 entry 255 committed", 9'd255, 24'h7E7F80);
        wr(2'd0, 8'd255);
        rd_chk("R4 read red 255", 2'd1, 8'h7E);
        rd_chk("R4 read green 255", 2'd1, 8'h7F);
        rd_chk("R4 read blue 255", 2'd1, 8'h80);
        rd_chk("R4 read wraps to 0", 2'd0, 8'h00);

        // R5 / R6: control window bounds.
        wr(2'd0, 8'd7); wr(2'd2, 8'h3C);
        rd_chk("R5 control reg 3", 2'd2, 8'h3C);
        wr(2'd0, 8'd8); wr(2'd2, 8'h5A);
        rd_chk("R6 read above window", 2'd2, 8'h00);
        wr(2'd0, 8'd3); wr(2'd2, 8'h66);
        rd_chk("R6 read below window", 2'd2, 8'h00);
        wr(2'd0, 8'd4);
        rd_chk("R6 reg 0 untouched", 2'd2, 8'hA5);
        wr(2'd0, 8'd7);
        rd_chk("R6 reg 3 untouched", 2'd2, 8'h3C);

        // R8: overlay port outside range.
        wr(2'd0, 8'd4); wr(2'd3, 8'hEE);
        rd_chk("R8 pointer unmoved", 2'd0, 8'd4);
        rd_chk("R8 read returns zero", 2'd3, 8'h00);
        wr(2'd3, 8'hEE); wr(2'd3, 8'hEE);
        idle();
        look_chk("R8 overlay 2 intact", 9'd258, 24'h010203);
        check("R8 no changed flag", 32'(pal_changed), 32'd0);

        // R7: overlay wrap after entry 3 and overlay read.
        wr(2'd0, 8'd3); wr(2'd3, 8'h44); wr(2'd3, 8'h55); wr(2'd3, 8'h66);
        rd_chk("R7 overlay wraps to 0", 2'd0, 8'h00);
        idle();
        look_chk("R7 overlay 3 at 259", 9'd259, 24'h445566);
        wr(2'd0, 8'd3);
        rd_chk("R7 overlay read red", 2'd3, 8'h44);
        rd_chk("R7 overlay read green", 2'd3, 8'h55);
        rd_chk("R7 overlay read blue", 2'd3, 8'h66);
        rd_chk("R7 overlay read wraps", 2'd0, 8'h00);

        // R10: colour numbers beyond the table.
        idle();
        look_chk("R10 number 260 is zero", 9'd260, 24'h000000);
        look_chk("R10 number 511 is zero", 9'd511, 24'h000000);

        summary();
    end
endmodule